// File: doc/BRIEF.md
# Commit-Gated Store Queue

This block sits between the store issue path of a processor pipeline and the data memory port. Stores arrive in program order with their address, data, byte enables and a tag once both operands are known. Each one waits in a small circular buffer until the in-order completion logic names its tag on the commit input. Only the oldest entry may go to memory, and only once it is committed, so no speculative store ever reaches memory.

A flush squashes every entry that has not been committed. Entries that are already committed stay in the queue and drain normally. A barrier input lets a synchronizing operation stop new stores and wait until the queue is empty. The queue accepts one store per clock. A store that is committed early can be offered to memory in the third cycle counted from its issue cycle.

Top module: `store_queue`

## Requirements
- R1: After synchronous reset the queue is empty: `mem_valid` is 0, `in_ready` is 1 and `sync_ok` is 1.
- R2: Stores leave on the memory port in the order they were accepted, and address, data, byte enables and tag arrive unchanged.
- R3: `mem_valid` is never high for an entry whose tag has not been committed in an earlier cycle.
- R4: A store accepted in cycle c is offered on `mem_valid` no earlier than cycle c+2. If it is committed in time and is at the head, it is offered in exactly cycle c+2.
- R5: With fewer than DEPTH (default 4) entries and `sync_req` low, `in_ready` is high, so back-to-back stores are accepted one per cycle.
- R6: With DEPTH entries held, `in_ready` is low and no entry is overwritten.
- R7: A flush removes every uncommitted entry in one cycle and keeps the committed ones. A commit in the same cycle as the flush still takes effect. A store presented in the flush cycle is dropped.
- R8: The head entry leaves only when `mem_valid` and `mem_ready` are both high. While `mem_ready` is low, `mem_valid` and the request fields hold steady.
- R9: While `sync_req` is high, `in_ready` is low. `sync_ok` is high exactly when the queue holds no entries.
- R10: A commit whose tag equals the tag of the store accepted in the same cycle commits that store.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A store is offered |
| in_ready | output | 1 | Queue can take a store this cycle |
| in_addr | input | 32 | Store address |
| in_data | input | 32 | Store data |
| in_be | input | 4 | Byte enables |
| in_tag | input | 4 | Completion tag of the store |
| cm_valid | input | 1 | Completion logic commits a tag |
| cm_tag | input | 4 | Tag being committed |
| flush | input | 1 | Squash all uncommitted entries |
| mem_valid | output | 1 | Head store offered to memory |
| mem_ready | input | 1 | Memory takes the offered store |
| mem_addr | output | 32 | Address of the offered store |
| mem_data | output | 32 | Data of the offered store |
| mem_be | output | 4 | Byte enables of the offered store |
| mem_tag | output | 4 | Tag of the offered store |
| sync_req | input | 1 | Synchronizing operation waiting |
| sync_ok | output | 1 | Queue is empty |

## Verification
A seeded random mix of issue, in-order commit, occasional flush, memory back-pressure and barrier requests is compared cycle by cycle against a reference queue kept in the bench. Each such run can show ordering or field corruption, an early or missing offer, and wrong ready values. Directed sequences then isolate single effects. A commit in the issue cycle separates exact three-cycle timing from off-by-one errors. Filling the queue without commits shows the full stall and the gating on commit. A flush in the same cycle as a commit shows whether the committed prefix survives. A barrier held over a draining queue shows the stall and the point at which the queue reports empty.

// File: rtl/sq_pkg.sv
`timescale 1ns/1ps
package sq_pkg;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int TAG_W  = 4;
    localparam int BE_W   = DATA_W / 8;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [BE_W-1:0]   be;
        logic [TAG_W-1:0]  tag;
    } sq_store_t;

    // circular pointer advance
    function automatic int unsigned wrap_add(int unsigned p, int unsigned n, int unsigned depth);
        return (p + n) % depth;
    endfunction
endpackage

// File: rtl/sq_slots.sv
`timescale 1ns/1ps
module sq_slots
    import sq_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int LAT   = 3,
    localparam int PW   = $clog2(DEPTH),
    localparam int AW   = $clog2(LAT + 1),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [PW-1:0]   wr_ptr,
    input  sq_store_t       wr_store,
    input  logic            cm_valid,
    input  logic [TAG_W-1:0] cm_tag,
    input  logic            pop_en,
    input  logic [PW-1:0]   rd_ptr,
    input  logic            flush,
    output sq_store_t       head_store,
    output logic            head_ok,
    output logic [CW-1:0]   keep_cnt
);
    logic [DEPTH-1:0] live;
    logic [DEPTH-1:0] cmt;
    logic [DEPTH-1:0] cmt_nx;
    logic [AW-1:0]    age [DEPTH];
    sq_store_t        body [DEPTH];
    logic             wr_cmt_now;

    assign wr_cmt_now = cm_valid && (cm_tag == wr_store.tag);

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic      v_q;
        logic      c_q;
        logic [AW-1:0] a_q;
        sq_store_t s_q;
        logic      hit, is_wr, is_pop;

        assign hit    = v_q && cm_valid && (s_q.tag == cm_tag);
        assign is_wr  = wr_en && (wr_ptr == PW'(i));
        assign is_pop = pop_en && (rd_ptr == PW'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                v_q <= 1'b0;
                c_q <= 1'b0;
                a_q <= '0;
            end else if (is_wr) begin
                v_q <= 1'b1;
                c_q <= wr_cmt_now;
                a_q <= AW'(1);
            end else if (is_pop || (flush && !(c_q || hit))) begin
                v_q <= 1'b0;
                c_q <= 1'b0;
            end else begin
                c_q <= c_q || hit;
                if (v_q && a_q != AW'(LAT - 1)) a_q <= a_q + AW'(1);
            end
        end

        always_ff @(posedge clk) begin
            if (is_wr) s_q <= wr_store;
        end

        assign live[i]   = v_q;
        assign cmt[i]    = c_q;
        assign cmt_nx[i] = c_q || hit;
        assign age[i]    = a_q;
        assign body[i]   = s_q;
    end

    assign head_store = body[rd_ptr];
    assign head_ok    = live[rd_ptr] && cmt[rd_ptr] && (age[rd_ptr] == AW'(LAT - 1));
    assign keep_cnt   = CW'($countones(live & cmt_nx));

    AST_NO_WRITE_OVER_LIVE: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !live[wr_ptr]); // R6
    AST_POP_ONLY_COMMITTED: assert property (@(posedge clk) disable iff (rst)
        pop_en |-> (live[rd_ptr] && cmt[rd_ptr])); // R3
endmodule

// File: rtl/sq_ptrs.sv
`timescale 1ns/1ps
module sq_ptrs
    import sq_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          pop_en,
    input  logic          flush,
    input  logic [CW-1:0] keep_cnt,
    output logic [PW-1:0] head,
    output logic [PW-1:0] tail,
    output logic [CW-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            head <= PW'(wrap_add(32'(head), 32'(pop_en), DEPTH));
            if (flush) begin
                tail  <= PW'(wrap_add(32'(head), 32'(keep_cnt), DEPTH));
                count <= keep_cnt - CW'(pop_en);
            end else begin
                tail  <= PW'(wrap_add(32'(tail), 32'(wr_en), DEPTH));
                count <= count + CW'(wr_en) - CW'(pop_en);
            end
        end
    end

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH)); // R6
    AST_FLUSH_SHRINK: assert property (@(posedge clk) disable iff (rst)
        flush |=> count <= $past(count)); // R7
endmodule

// File: rtl/store_queue.sv
`timescale 1ns/1ps
module store_queue
    import sq_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int LAT   = 3,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_data,
    input  logic [BE_W-1:0]   in_be,
    input  logic [TAG_W-1:0]  in_tag,
    input  logic              cm_valid,
    input  logic [TAG_W-1:0]  cm_tag,
    input  logic              flush,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data,
    output logic [BE_W-1:0]   mem_be,
    output logic [TAG_W-1:0]  mem_tag,
    input  logic              sync_req,
    output logic              sync_ok
);
    logic [PW-1:0] head, tail;
    logic [CW-1:0] count, keep_cnt;
    logic          wr_en, pop_en, head_ok;
    sq_store_t     in_store, head_store;

    assign in_store = '{addr: in_addr, data: in_data, be: in_be, tag: in_tag};
    assign in_ready = (count < CW'(DEPTH)) && !sync_req;
    assign wr_en    = in_valid && in_ready && !flush;
    assign mem_valid = head_ok;
    assign pop_en   = head_ok && mem_ready;
    assign sync_ok  = (count == '0);

    assign mem_addr = head_store.addr;
    assign mem_data = head_store.data;
    assign mem_be   = head_store.be;
    assign mem_tag  = head_store.tag;

    sq_slots #(.DEPTH(DEPTH), .LAT(LAT)) u_slots (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ptr(tail), .wr_store(in_store),
        .cm_valid(cm_valid), .cm_tag(cm_tag), .pop_en(pop_en), .rd_ptr(head),
        .flush(flush), .head_store(head_store), .head_ok(head_ok), .keep_cnt(keep_cnt)
    );

    sq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .pop_en(pop_en), .flush(flush),
        .keep_cnt(keep_cnt), .head(head), .tail(tail), .count(count)
    );

    AST_HOLD_REQ: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_tag))); // R8
    AST_SYNC_STALL: assert property (@(posedge clk) disable iff (rst)
        sync_req |-> !in_ready); // R9
    AST_FIRST_GAP: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sync_ok) |=> !mem_valid); // R4
endmodule

// File: tb/store_queue_test.sv
`timescale 1ns/1ps
module store_queue_test;
    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid, in_ready;
    logic [31:0] in_addr, in_data;
    logic [3:0]  in_be, in_tag;
    logic        cm_valid;
    logic [3:0]  cm_tag;
    logic        flush, mem_valid, mem_ready;
    logic [31:0] mem_addr, mem_data;
    logic [3:0]  mem_be, mem_tag;
    logic        sync_req, sync_ok;

    always #10 clk = ~clk;

    store_queue uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_addr(in_addr), .in_data(in_data), .in_be(in_be), .in_tag(in_tag),
        .cm_valid(cm_valid), .cm_tag(cm_tag), .flush(flush),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
        .mem_data(mem_data), .mem_be(mem_be), .mem_tag(mem_tag),
        .sync_req(sync_req), .sync_ok(sync_ok)
    );

    typedef struct {
        logic [31:0] a;
        logic [31:0] d;
        logic [3:0]  be;
        logic [3:0]  tg;
        bit          cmt;
        bit          early;
        int          iss;
    } ment_t;

    ment_t m[$];
    int    cyc = 0;
    int    n_chk = 0;
    int    n_err = 0;
    bit    done = 0;
    bit    prev_hold = 0;
    bit    prev_flush = 0;
    logic [31:0] prev_addr;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic bit exp_mv();
        return (m.size() > 0) && m[0].cmt && (cyc - m[0].iss >= 2);
    endfunction

    task automatic step(input bit iv, input logic [31:0] a, input logic [31:0] d,
                        input logic [3:0] be, input logic [3:0] tg,
                        input bit cv, input logic [3:0] ct,
                        input bit fl, input bit mr, input bit sy);
        bit er, emv;
        string lbl;
        @(negedge clk);
        in_valid = iv; in_addr = a; in_data = d; in_be = be; in_tag = tg;
        cm_valid = cv; cm_tag = ct; flush = fl; mem_ready = mr; sync_req = sy;
        #1;
        er  = (m.size() < DEPTH) && !sy;
        emv = exp_mv();
        lbl = sy ? "R9" : ((m.size() == DEPTH) ? "R6" : "R5");
        chk(in_ready == er, lbl, 64'(in_ready), 64'(er));
        if (m.size() > 0 && !m[0].cmt) lbl = "R3";
        else if (emv && m[0].early)    lbl = "R10";
        else                           lbl = "R4";
        chk(mem_valid == emv, lbl, 64'(mem_valid), 64'(emv));
        if (emv && mem_valid) begin
            chk({mem_addr, mem_data} == {m[0].a, m[0].d}, "R2", {mem_addr, mem_data}, {m[0].a, m[0].d});
            chk({mem_be, mem_tag} == {m[0].be, m[0].tg}, "R2", 64'({mem_be, mem_tag}), 64'({m[0].be, m[0].tg}));
        end
        if (prev_hold)
            chk(mem_valid && mem_addr == prev_addr, "R8", 64'(mem_addr), 64'(prev_addr));
        chk(sync_ok == (m.size() == 0), prev_flush ? "R7" : "R9", 64'(sync_ok), 64'(m.size() == 0));
        // reference update, in the order the edge applies it
        if (cv) foreach (m[i]) if (m[i].tg == ct) m[i].cmt = 1;
        prev_hold = emv && !mr;
        prev_addr = emv ? m[0].a : 32'h0;
        if (emv && mr) void'(m.pop_front());
        if (fl) while (m.size() > 0 && !m[m.size()-1].cmt) void'(m.pop_back());
        if (iv && er && !fl)
            m.push_back('{a: a, d: d, be: be, tg: tg, cmt: (cv && ct == tg),
                          early: (cv && ct == tg), iss: cyc});
        prev_flush = fl;
        cyc++;
    endtask

    task automatic idle(input bit mr);
        step(0, 32'h0, 32'h0, 4'h0, 4'h0, 0, 4'h0, 0, mr, 0);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [3:0] tagc;
        void'($urandom(32'd20250607));
        rst = 1; in_valid = 0; in_addr = 0; in_data = 0; in_be = 0; in_tag = 0;
        cm_valid = 0; cm_tag = 0; flush = 0; mem_ready = 0; sync_req = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        chk(mem_valid == 0, "R1", 64'(mem_valid), 64'd0);
        chk(in_ready == 1, "R1", 64'(in_ready), 64'd1);
        chk(sync_ok == 1, "R1", 64'(sync_ok), 64'd1);

        // R10 / R4: commit in issue cycle, offered exactly two cycles later
        step(1, 32'h1000, 32'hA5A5_0001, 4'hF, 4'h1, 1, 4'h1, 0, 1, 0);
        idle(1);
        idle(1);
        idle(1);

        // R5 / R6 / R3: fill without commit, then stall
        for (int k = 0; k < 6; k++)
            step(1, 32'h2000 + 32'(k*4), 32'h100 + 32'(k), 4'h3, 4'(2 + k), 0, 4'h0, 0, 1, 0);
        idle(1);
        // R7: commit oldest, then flush while committing the second
        step(0, 0, 0, 0, 0, 1, 4'h2, 0, 0, 0);
        step(1, 32'h3000, 32'h3, 4'h1, 4'hE, 1, 4'h3, 1, 0, 0);
        idle(0);
        idle(0);
        // R9: barrier held over a draining queue
        for (int k = 0; k < 5; k++)
            step(1, 32'h4000, 32'h4, 4'h1, 4'hD, 0, 4'h0, 0, 1, 1);
        idle(1);

        // random mix
        tagc = 4'h5;
        for (int n = 0; n < 4000; n++) begin
            bit iv, cv, fl, mr, sy;
            logic [3:0] ct;
            int oldest;
            iv = ($urandom % 4) != 0;
            fl = ($urandom % 40) == 0;
            mr = ($urandom % 4) != 0;
            sy = ($urandom % 30) == 0;
            cv = 0; ct = 4'h0; oldest = -1;
            foreach (m[i]) if (!m[i].cmt && oldest < 0) oldest = i;
            if (oldest >= 0 && ($urandom % 2) == 0) begin
                cv = 1; ct = m[oldest].tg;
            end else if (oldest < 0 && iv && ($urandom % 3) == 0) begin
                cv = 1; ct = tagc;
            end
            step(iv, $urandom, $urandom, 4'($urandom), tagc, cv, ct, fl, mr, sy);
            if (iv && !fl && (m.size() > 0) && m[m.size()-1].tg == tagc && m[m.size()-1].iss == cyc - 1)
                tagc = tagc + 4'h1;
        end
        repeat (8) idle(1);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule